// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one write transaction into a page-sized holding buffer. When the transaction is closed, it copies them into the storage array during a self-timed programming interval of fixed length. A transaction opens with a start strobe that carries a word address. The upper address bits pick the page row and the lower bits pick the first in-page offset. Each load strobe then stores one byte at the current offset and advances the offset modulo the page size. The row never changes, so an overlong transaction wraps to offset 0 and overwrites earlier bytes of the same page.

A stop strobe starts programming, but only if at least one byte was loaded. The busy flag is then held high for a fixed number of clock cycles. During that interval every strobe is ignored. The array write port visits each in-page offset once, in ascending order, and writes only the offsets that were loaded. When the write-protect input is high at the stop, the interval still runs but nothing is written. At the end of the interval the buffer's loaded-byte mask is cleared. The block also presents the address that follows the last loaded byte, wrapped within the page, for use by a shared address counter.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, busy_o, arr_we_o and next_addr_o are all zero.
- R2: start_i latches page row = addr_i / PAGE_BYTES and offset = addr_i mod PAGE_BYTES. Each load_i stores data_i at the current offset and then advances the offset modulo PAGE_BYTES. The row stays fixed, so the byte after offset PAGE_BYTES-1 lands at offset 0 of the same page.
- R3: A byte loaded into an offset that was already loaded in the same transaction replaces the earlier byte. Only the last value reaches the array.
- R4: A commit writes exactly the offsets loaded since the last start_i. start_i clears the loaded-byte mask. Other array locations keep their contents.
- R5: A stop_i that is not ignored, and that follows at least one loaded byte, raises busy_o from the next cycle for exactly PROG_CYCLES cycles.
- R6: A stop_i with no loaded byte starts no programming: busy_o stays low and nothing is written. This also holds for a stop_i right after a completed commit.
- R7: While busy_o is high, start_i, load_i and stop_i have no effect. The buffer, the mask, the following address and the array contents are untouched, and no second interval follows.
- R8: If wp_i is high in the cycle stop_i is accepted, arr_we_o stays low for the whole interval. The interval still lasts PROG_CYCLES cycles.
- R9: From the end of a commit, next_addr_o = row * PAGE_BYTES + ((first offset + bytes loaded) mod PAGE_BYTES).
- R10: In busy cycle k (k = 0 is the first cycle busy_o is high), arr_we_o is high only if k < PAGE_BYTES and offset k was loaded. arr_addr_o is then row * PAGE_BYTES + k and arr_data_o is the byte held for offset k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a write transaction at addr_i |
| addr_i | input | AW | Word address for start_i |
| load_i | input | 1 | Stores data_i at the current offset |
| data_i | input | 8 | Data byte for load_i |
| stop_i | input | 1 | Closes the transaction and starts the commit |
| wp_i | input | 1 | Write protect, sampled with stop_i |
| busy_o | output | 1 | Programming interval in progress |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | AW | Array write address |
| arr_data_o | output | 8 | Array write data |
| next_addr_o | output | AW | Address after the last loaded byte |

## Verification
The bench builds the block with a 4-byte page, a 32-entry array and a 6-cycle programming interval. At that size, every start offset can be combined with every transaction length from 1 to 6 bytes. The longer lengths wrap, overwrite earlier bytes, and land next_addr_o on each offset. The short interval also lets the whole array image be compared against an arithmetic model after every commit. It leaves room to inject strobes during busy and to cover both write-protect settings.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pwc_prog_timer.sv
module pwc_prog_timer #(
  parameter int CYCLES = 16,
  parameter int CW     = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  output logic          busy_o,
  output logic [CW-1:0] phase_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LastPhase = CW'(CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (fire_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LastPhase) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign phase_o = cnt_q;
  assign done_o  = busy_q && (cnt_q == LastPhase);

  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(cnt_q) == LastPhase);

  // R5
  phase_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> cnt_q == '0);
endmodule

// File: rtl/pwc_page_store.sv
module pwc_page_store
  import pwc_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int AW         = 11,
  localparam int OW        = $clog2(PAGE_BYTES),
  localparam int RW        = AW - OW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  busy_i,
  input  logic                  clear_i,
  input  logic                  start_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  load_i,
  input  byte_t                 data_i,
  input  logic [OW-1:0]         rd_off_i,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic [RW-1:0]         row_o,
  output logic [OW-1:0]         ptr_o,
  output byte_t                 rd_data_o
);
  byte_t                 buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [RW-1:0]         row_q;
  logic [OW-1:0]         ptr_q;
  logic                  take_byte;

  assign take_byte = !busy_i && !start_i && load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      row_q  <= '0;
      ptr_q  <= '0;
    end else if (clear_i) begin
      mask_q <= '0;
    end else if (!busy_i) begin
      if (start_i) begin
        row_q  <= addr_i[AW-1:OW];
        ptr_q  <= addr_i[OW-1:0];
        mask_q <= '0;
      end else if (load_i) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;  // wraps inside the page
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_byte) buf_q[ptr_q] <= data_i;
  end

  assign mask_o    = mask_q;
  assign row_o     = row_q;
  assign ptr_o     = ptr_q;
  assign rd_data_o = buf_q[rd_off_i];

  // R7
  mask_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i) && busy_i) |-> ($stable(mask_q) && $stable(ptr_q) && $stable(row_q)));
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import pwc_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int DEPTH       = 2048,
  parameter int PROG_CYCLES = 500000,
  localparam int AW         = $clog2(DEPTH),
  localparam int OW         = $clog2(PAGE_BYTES),
  localparam int RW         = AW - OW,
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          load_i,
  input  logic [7:0]    data_i,
  input  logic          stop_i,
  input  logic          wp_i,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_data_o,
  output logic [AW-1:0] next_addr_o
);
  logic                  busy, done, fire, wp_q, in_page;
  logic [CW-1:0]         phase;
  logic [OW-1:0]         off, ptr;
  logic [RW-1:0]         row;
  logic [PAGE_BYTES-1:0] mask;
  byte_t                 rd_data;
  logic [AW-1:0]         next_q;

  assign fire    = stop_i && !busy && (|mask);
  assign off     = phase[OW-1:0];
  assign in_page = phase < CW'(PAGE_BYTES);

  pwc_prog_timer #(.CYCLES(PROG_CYCLES), .CW(CW)) timer_i (
    .clk_i, .rst_ni, .fire_i(fire), .busy_o(busy), .phase_o(phase), .done_o(done)
  );

  pwc_page_store #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) store_i (
    .clk_i, .rst_ni, .busy_i(busy), .clear_i(done), .start_i, .addr_i, .load_i,
    .data_i(byte_t'(data_i)), .rd_off_i(off), .mask_o(mask), .row_o(row),
    .ptr_o(ptr), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= 1'b0;
      next_q <= '0;
    end else begin
      if (fire) wp_q <= wp_i;
      if (done) next_q <= {row, ptr};
    end
  end

  assign busy_o      = busy;
  assign arr_we_o    = busy && in_page && mask[off] && !wp_q;
  assign arr_addr_o  = {row, off};
  assign arr_data_o  = rd_data;
  assign next_addr_o = next_q;

  // R8
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> !wp_q);

  // R10
  we_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  // R6
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && mask == '0) |=> !busy_o);
endmodule

// File: tb/page_commit_buf_tb_top.sv
`timescale 1ns/1ps
module page_commit_buf_tb_top;
  localparam int P    = 4;
  localparam int D    = 32;
  localparam int PROG = 6;
  localparam int AW   = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, load_i = 0, stop_i = 0, wp_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic busy_o, arr_we_o;
  logic [AW-1:0] arr_addr_o, next_addr_o;
  logic [7:0] arr_data_o;

  int total = 0, failed = 0, wcnt = 0, bcyc = 0;
  logic [7:0] mem [D];
  logic [7:0] exp_mem [D];

  always #4 clk_i = ~clk_i;

  page_commit_buf #(.PAGE_BYTES(P), .DEPTH(D), .PROG_CYCLES(PROG)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // array model fed by the write port
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o) begin
        if (arr_we_o) begin
          mem[arr_addr_o] = arr_data_o;
          wcnt++;
          chk(int'(arr_addr_o) % P == bcyc, "R10 write offset", int'(arr_addr_o) % P, bcyc);
        end
        bcyc++;
      end else bcyc = 0;
    end
  end

  function automatic logic [7:0] dval(input int tx, input int i);
    return 8'(tx * 37 + i * 11 + 5);
  endfunction

  task automatic check_image(input string req);
    int bad = 0;
    for (int a = 0; a < D; a++) if (mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  // count busy cycles starting at the negedge after the stop edge
  task automatic wait_busy(output int bl, input bit junk);
    bl = 0;
    while (busy_o) begin
      bl++;
      if (junk) begin
        start_i = 1; addr_i = AW'(D - 1); load_i = 1; data_i = 8'hA5; stop_i = 1;
      end
      @(negedge clk_i);
    end
    start_i = 0; load_i = 0; stop_i = 0;
  endtask

  task automatic run_tx(input int tx, input int row, input int s, input int n,
                        input bit wp, input bit junk);
    int bl;
    int distinct = 0;
    bit seen [P];
    for (int k = 0; k < P; k++) seen[k] = 0;
    wcnt = 0;
    @(negedge clk_i);
    start_i = 1; addr_i = AW'(row * P + s);
    @(negedge clk_i);
    start_i = 0;
    for (int i = 0; i < n; i++) begin
      load_i = 1; data_i = dval(tx, i);
      @(negedge clk_i);
      if (!wp) exp_mem[row * P + (s + i) % P] = dval(tx, i);
      if (!seen[(s + i) % P]) begin seen[(s + i) % P] = 1; distinct++; end
    end
    load_i = 0; stop_i = 1; wp_i = wp;
    @(negedge clk_i);
    stop_i = 0; wp_i = 0;
    wait_busy(bl, junk);
    chk(bl == PROG, "R5 busy length", bl, PROG);
    chk(wcnt == (wp ? 0 : distinct), wp ? "R8 no writes" : "R4 write count", wcnt, wp ? 0 : distinct);
    check_image(wp ? "R8 array image" : "R2 R3 R4 array image");
    chk(int'(next_addr_o) == row * P + (s + n) % P, "R9 next address",
        int'(next_addr_o), row * P + (s + n) % P);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failed++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int tx = 0;
    int bl;
    for (int a = 0; a < D; a++) begin mem[a] = 8'h00; exp_mem[a] = 8'h00; end
    repeat (3) @(negedge clk_i);
    // R1
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(arr_we_o == 0, "R1 we", arr_we_o, 0);
    chk(next_addr_o == 0, "R1 next", next_addr_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R6: stop with empty buffer after reset
    stop_i = 1; @(negedge clk_i); stop_i = 0; @(negedge clk_i);
    chk(busy_o == 0, "R6 empty stop", busy_o, 0);
    // sweep over start offset and length (R2 R3 R4 R5 R9 R10)
    for (int s = 0; s < P; s++)
      for (int n = 1; n <= P + 2; n++) begin
        run_tx(tx, (s * 6 + n) % (D / P), s, n, 0, 0);
        tx++;
      end
    // R6: stop right after a commit
    stop_i = 1; @(negedge clk_i); stop_i = 0; @(negedge clk_i);
    chk(busy_o == 0, "R6 stop after commit", busy_o, 0);
    // R7: strobes during busy are ignored
    run_tx(tx, 2, 1, 3, 0, 1); tx++;
    repeat (2) @(negedge clk_i);
    chk(busy_o == 0, "R7 no second interval", busy_o, 0);
    check_image("R7 array untouched");
    chk(int'(next_addr_o) == 2 * P + 0, "R7 next address kept", int'(next_addr_o), 2 * P);
    // R8: write-protected commit, both short and wrapping
    run_tx(tx, 5, 0, 2, 1, 0); tx++;
    run_tx(tx, 6, 3, 5, 1, 0); tx++;
    // unprotected again after protection
    run_tx(tx, 5, 2, 1, 0, 0); tx++;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule